// File: doc/BRIEF.md
# Polarity-Programmable Level Interrupt Controller

This block merges four external digital lines into a single host interrupt request. Each line first passes through a two-stage synchroniser. The synchronised level is then XORed with a per-line inversion bit and gated by a per-line enable bit. The request is raised while any gated line is high, so the interrupt is level-sensitive and is not latched on an edge.

A small request state machine registers the result. It has two states, `REQ_IDLE` and `REQ_RAISED`. The transition IDLE→RAISED is taken when some enabled, polarity-adjusted line is high. The transition RAISED→IDLE is taken when none is high. Each state holds itself otherwise.

Software reaches the block through a byte-wide register port that has an address, a write strobe, a read strobe, write data and read data. To count both edges of a pulse, the service routine reads the raw levels from the status register and then flips that line's inversion bit. This removes the line's active condition until the opposite edge arrives.

Top module: `lvl_irq_ctrl`

## Requirements
- R1: After reset, `irq_req` is 0, and the enable register and the inversion register both read 0x00.
- R2: The enable register sits at address 0x05. Bit i enables line i for i = 0..3. A write sets it from `bus_wdata[3:0]`. A read returns it.
- R3: The inversion register sits at address 0x2A. Bit i set to 1 inverts line i, and bit i set to 0 passes line i unchanged. It is written and read like R2.
- R4: Bits 7..4 of the enable and inversion registers always read 0, and writes to those bits have no effect. A write to any other address leaves both registers unchanged.
- R5: A read of address 0x07 returns the synchronised raw line levels in bits 3..0, with line i in bit i, and 0 in bits 7..4. The value does not depend on the inversion bits.
- R6: `irq_req` equals the OR over i of (enable[i] AND (line[i] XOR inversion[i])). A change on `src_line` reaches `irq_req` at the third rising clock edge after the change.
- R7: While the enable register is 0, `irq_req` is 0 whatever the line levels and inversion bits are.
- R8: A write to the inversion register changes `irq_req` one clock edge after the edge that captures the write. When the line is steady, the request therefore drops at the second edge after the write strobe is sampled.
- R9: Read data is registered. `bus_rdata` is updated at the rising edge that samples `bus_rd` and holds its value until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_line | input | 4 | Asynchronous interrupt source lines |
| bus_addr | input | 8 | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| irq_req | output | 1 | Level interrupt request to the host |

## Verification
The bench sweeps every combination of the enable, inversion and line values, 4096 in all. It compares the request against the arithmetic rule and the status readback against the raw lines. A design that XORed the status with the inversion bits, or swapped the role of the inversion bit, would fail on half of these patterns. The bench also measures the exact latency of a polarity write and of a line change, which catches a missing or extra pipeline stage. It writes all ones and writes to unmapped addresses, which catches upper register bits that hold data or an address decode that is too loose.

// File: rtl/lvl_irq_pkg.sv
package lvl_irq_pkg;
    localparam int N_SRC    = 4;
    localparam int DATA_W   = 8;
    localparam int ADDR_W   = 8;
    localparam int SYNC_STG = 2;

    localparam logic [ADDR_W-1:0] ADR_ENABLE = 8'h05;
    localparam logic [ADDR_W-1:0] ADR_STATUS = 8'h07;
    localparam logic [ADDR_W-1:0] ADR_INVERT = 8'h2A;

    typedef enum logic {
        REQ_IDLE   = 1'b0,
        REQ_RAISED = 1'b1
    } req_state_t;
endpackage

// File: rtl/lvl_irq_sync.sv
module lvl_irq_sync #(
    parameter int W      = 4,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] stg [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[0] <= '0;
        else        stg[0] <= din;
    end

    generate
        for (genvar s = 1; s < STAGES; s++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stg[s] <= '0;
                else        stg[s] <= stg[s-1];
            end
        end
    endgenerate

    assign dout = stg[STAGES-1];
endmodule

// File: rtl/lvl_irq_regs.sv
module lvl_irq_regs
    import lvl_irq_pkg::*;
#(
    parameter int NS = N_SRC,
    parameter int DW = DATA_W,
    parameter int AW = ADDR_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] addr,
    input  logic          wr_stb,
    input  logic          rd_stb,
    input  logic [DW-1:0] wdata,
    input  logic [NS-1:0] lvl,
    output logic [DW-1:0] rdata,
    output logic [NS-1:0] en_q,
    output logic [NS-1:0] pol_q
);
    localparam int PAD = DW - NS;

    logic [DW-1:0] rd_mux;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q  <= '0;
            pol_q <= '0;
        end else if (wr_stb) begin
            if (addr == ADR_ENABLE) en_q  <= wdata[NS-1:0];
            if (addr == ADR_INVERT) pol_q <= wdata[NS-1:0];
        end
    end

    always_comb begin
        unique case (addr)
            ADR_ENABLE: rd_mux = {{PAD{1'b0}}, en_q};
            ADR_INVERT: rd_mux = {{PAD{1'b0}}, pol_q};
            ADR_STATUS: rd_mux = {{PAD{1'b0}}, lvl};
            default:    rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      rdata <= '0;
        else if (rd_stb) rdata <= rd_mux;
    end

    // R2
    en_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(wr_stb) && $past(addr) == ADR_ENABLE)
        |-> en_q == $past(wdata[NS-1:0]));

    // R3
    pol_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !($past(wr_stb) && $past(addr) == ADR_INVERT))
        |-> $stable(pol_q));

    // R4
    upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(rd_stb) &&
         ($past(addr) == ADR_ENABLE || $past(addr) == ADR_INVERT))
        |-> rdata[DW-1:NS] == '0);
endmodule

// File: rtl/lvl_irq_ctrl.sv
module lvl_irq_ctrl
    import lvl_irq_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic [3:0]  src_line,
    input  logic [7:0]  bus_addr,
    input  logic        bus_wr,
    input  logic        bus_rd,
    input  logic [7:0]  bus_wdata,
    output logic [7:0]  bus_rdata,
    output logic        irq_req
);
    logic [N_SRC-1:0] lvl_s;
    logic [N_SRC-1:0] en_q;
    logic [N_SRC-1:0] pol_q;
    logic             pending;
    req_state_t       state_q, state_d;

    lvl_irq_sync #(.W(N_SRC), .STAGES(SYNC_STG)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (src_line),
        .dout (lvl_s)
    );

    lvl_irq_regs #(.NS(N_SRC), .DW(DATA_W), .AW(ADDR_W)) u_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .addr  (bus_addr),
        .wr_stb(bus_wr),
        .rd_stb(bus_rd),
        .wdata (bus_wdata),
        .lvl   (lvl_s),
        .rdata (bus_rdata),
        .en_q  (en_q),
        .pol_q (pol_q)
    );

    assign pending = |(en_q & (lvl_s ^ pol_q));

    always_comb begin
        unique case (state_q)
            REQ_IDLE:   state_d = pending ? REQ_RAISED : REQ_IDLE;
            REQ_RAISED: state_d = pending ? REQ_RAISED : REQ_IDLE;
            default:    state_d = REQ_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= REQ_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        irq_req = (state_q == REQ_RAISED);
    end

    // R7
    masked_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en_q == '0) |=> !irq_req);
endmodule

// File: tb/sim_lvl_irq_ctrl.sv
module sim_lvl_irq_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] src_line = '0;
    logic [7:0] bus_addr = '0;
    logic       bus_wr = 1'b0;
    logic       bus_rd = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       irq_req;

    int n_chk = 0;
    int n_err = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    lvl_irq_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .src_line(src_line),
        .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_req(irq_req)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [7:0] d);
        bus_addr = a; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    initial begin : wdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++; n_err++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin : main
        logic [7:0] r;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 irq", {7'd0, irq_req}, 8'h00);
        rd(8'h05, r); chk("R1 enable", r, 8'h00);
        rd(8'h2A, r); chk("R1 invert", r, 8'h00);

        // R4 upper bits and unmapped addresses
        wr(8'h05, 8'hFF); rd(8'h05, r); chk("R4 enable upper", r, 8'h0F);
        wr(8'h2A, 8'hF5); rd(8'h2A, r); chk("R4 invert upper", r, 8'h05);
        wr(8'h10, 8'h00); wr(8'h06, 8'h00); wr(8'h07, 8'h00);
        rd(8'h05, r); chk("R4 unmapped keeps enable", r, 8'h0F);
        rd(8'h2A, r); chk("R4 unmapped keeps invert", r, 8'h05);

        // R9 read data holds between reads
        bus_addr = 8'h2A;
        repeat (2) @(negedge clk);
        chk("R9 rdata hold", bus_rdata, 8'h05);
        rd(8'h05, r); chk("R9 rdata update", r, 8'h0F);

        // R7 enable zero masks everything
        wr(8'h05, 8'h00);
        for (int l = 0; l < 16; l++) begin
            src_line = l[3:0];
            repeat (3) @(negedge clk);
            chk("R7 masked", {7'd0, irq_req}, 8'h00);
        end

        // R6 line-change latency: third edge after change
        wr(8'h2A, 8'h00); wr(8'h05, 8'h01);
        src_line = 4'h0;
        repeat (4) @(negedge clk);
        src_line = 4'h1;
        repeat (2) @(negedge clk);
        chk("R6 latency not yet", {7'd0, irq_req}, 8'h00);
        @(negedge clk);
        chk("R6 latency raised", {7'd0, irq_req}, 8'h01);

        // R8 polarity-write latency, line steady high
        wr(8'h2A, 8'h01);
        chk("R8 one edge after write", {7'd0, irq_req}, 8'h01);
        @(negedge clk);
        chk("R8 dropped", {7'd0, irq_req}, 8'h00);
        // opposite edge re-arms with inverted polarity
        src_line = 4'h0;
        repeat (3) @(negedge clk);
        chk("R8 opposite edge", {7'd0, irq_req}, 8'h01);

        // R2 R3 R5 R6 exhaustive sweep
        for (int e = 0; e < 16; e++) begin
            for (int p = 0; p < 16; p++) begin
                wr(8'h05, e[7:0]);
                wr(8'h2A, p[7:0]);
                rd(8'h05, r); chk("R2 enable readback", r, e[7:0]);
                rd(8'h2A, r); chk("R3 invert readback", r, p[7:0]);
                for (int l = 0; l < 16; l++) begin
                    src_line = l[3:0];
                    repeat (3) @(negedge clk);
                    chk("R6 request", {7'd0, irq_req},
                        {7'd0, |(e[3:0] & (l[3:0] ^ p[3:0]))});
                    if (((e + p) & 3) == 0) begin
                        rd(8'h07, r); chk("R5 status", r, l[7:0]);
                    end
                end
            end
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule